// File: doc/BRIEF.md
# Octal Double-Buffered DAC Code Register Front End

This block is the digital front end of an eight-channel, 13-bit digital-to-analog converter. A shared parallel data bus and a 3-bit channel select feed eight input (staging) registers. An active-low chip-select and an active-low write strobe open a write window. A second active-low strobe, the update strobe, copies every staging register into its channel's output register at the same time. An active-low clear forces every channel to its offset condition and leaves the stored codes untouched.

The strobes behave as level-sensitive latches, but the design samples them with a clock that is much faster than the strobes, so only flip-flops are built. While a stage is open, its registers take a new value on every clock edge. When the stage closes, they keep the last value sampled. Every input reaches the outputs in exactly one clock edge, and this includes the case where the bus value passes through both stages in the same cycle.

Top module: `dacif_octal`

## Requirements
- R1: After synchronous reset, every channel code reads 0, every forced-offset flag reads 0, and all staging and output registers hold 0.
- R2: The channel select is a plain binary index: value k (000 through 111) selects channel k. A write affects only the staging register of the selected channel, and the other seven keep their values.
- R3: While `cs_n` and `wr_n` are both 0, the selected staging register takes the bus value on every clock edge. When either strobe is 1 at an edge, the register keeps the last value it took, and later bus changes have no effect on it.
- R4: If the channel select changes while the write window stays open, the newly selected channel follows the bus from that edge onward. The channel selected before keeps the last value it took while it was selected.
- R5: While `upd_n` is 0, all eight output registers take their staging register values, including staging values written at that same edge. While `upd_n` is 1, the output registers and the reported codes do not change.
- R6: When `cs_n`, `wr_n` and `upd_n` are all 0, the bus value sampled at an edge appears on the selected channel's code output right after that same edge.
- R7: While `clr_n` is 0, every code output reads 0 and every forced-offset flag reads 1, one edge after sampling. When `clr_n` returns to 1, each channel again shows its output register after one edge. Clear does not change the stored staging or output values.
- R8: A write or an update performed while clear is asserted still changes the stored registers, and the new values appear as soon as clear is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the strobes |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| upd_n | input | 1 | Active-low update strobe, staging to output rank |
| clr_n | input | 1 | Active-low clear to offset |
| sel | input | 3 | Channel select for writes |
| din | input | 13 | Shared data bus |
| code_o | output | 8x13 | Per-channel reported code, channel k in slice k |
| forced_o | output | 8 | Per-channel forced-offset flag |

## Verification
The directed cases target these faults. If the channel select changes inside an open write window, a design that latched the select at the window's opening would write the wrong channel. If writes and updates overlap, a design that chains the two ranks through a register would show the bus value one edge late, and a design that ignores same-edge writes would lose the newest code. If clear is asserted during an update, a design that wipes the stored codes, or that blocks updates while clear is active, would show zeros or stale data once clear is released. Random strobe and bus patterns with a fixed seed are compared every cycle against a bench model of the two ranks.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    localparam int NCH    = 8;
    localparam int CODE_W = 13;
    localparam int SEL_W  = $clog2(NCH);

    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic upd_n;
        logic clr_n;
    } strobe_t;

    function automatic logic write_open(strobe_t s);
        return !s.cs_n && !s.wr_n;
    endfunction

    function automatic logic update_open(strobe_t s);
        return !s.upd_n;
    endfunction

    function automatic logic clear_active(strobe_t s);
        return !s.clr_n;
    endfunction

endpackage

// File: rtl/dacif_stage_rank.sv
module dacif_stage_rank #(
    parameter int NCH    = 8,
    parameter int CODE_W = 13,
    parameter int SEL_W  = $clog2(NCH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wen,
    input  logic [SEL_W-1:0]              sel,
    input  logic [CODE_W-1:0]             din,
    output logic [NCH-1:0][CODE_W-1:0]    stg_nxt,
    output logic [NCH-1:0][CODE_W-1:0]    stg_q
);

    logic [NCH-1:0] hit;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            hit[i]     = wen && (sel == SEL_W'(i));
            stg_nxt[i] = hit[i] ? din : stg_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= stg_nxt;
    end

    assert_closed_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wen |=> $stable(stg_q));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assert_other_hold_R2: assert property (@(posedge clk) disable iff (rst)
            (wen && sel != SEL_W'(g)) |=> $stable(stg_q[g]));
        assert_follow_R4: assert property (@(posedge clk) disable iff (rst)
            (wen && sel == SEL_W'(g)) |=> stg_q[g] == $past(din));
    end

endmodule

// File: rtl/dacif_out_rank.sv
module dacif_out_rank #(
    parameter int NCH    = 8,
    parameter int CODE_W = 13
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          upd_en,
    input  logic [NCH-1:0][CODE_W-1:0]    stg_nxt,
    input  logic [NCH-1:0][CODE_W-1:0]    stg_q,
    output logic [NCH-1:0][CODE_W-1:0]    dac_nxt,
    output logic [NCH-1:0][CODE_W-1:0]    dac_q
);

    always_comb dac_nxt = upd_en ? stg_nxt : dac_q;

    always_ff @(posedge clk) begin
        if (rst) dac_q <= '0;
        else     dac_q <= dac_nxt;
    end

    assert_update_copy_R5: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> dac_q == stg_q);
    assert_update_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(dac_q));

endmodule

// File: rtl/dacif_out_stage.sv
module dacif_out_stage #(
    parameter int NCH    = 8,
    parameter int CODE_W = 13
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr_en,
    input  logic [NCH-1:0][CODE_W-1:0]    dac_nxt,
    input  logic [NCH-1:0][CODE_W-1:0]    dac_q,
    output logic [NCH-1:0][CODE_W-1:0]    code_o,
    output logic [NCH-1:0]                forced_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o   <= '0;
            forced_o <= '0;
        end else begin
            forced_o <= {NCH{clr_en}};
            for (int i = 0; i < NCH; i++)
                code_o[i] <= clr_en ? '0 : dac_nxt[i];
        end
    end

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> (code_o == '0) && (&forced_o));
    assert_release_show_R7: assert property (@(posedge clk) disable iff (rst)
        !clr_en |=> (code_o == dac_q) && (forced_o == '0));

endmodule

// File: rtl/dacif_octal.sv
module dacif_octal
    import dacif_pkg::*;
#(
    parameter int NCH    = dacif_pkg::NCH,
    parameter int CODE_W = dacif_pkg::CODE_W,
    parameter int SEL_W  = $clog2(NCH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_n,
    input  logic                          wr_n,
    input  logic                          upd_n,
    input  logic                          clr_n,
    input  logic [SEL_W-1:0]              sel,
    input  logic [CODE_W-1:0]             din,
    output logic [NCH-1:0][CODE_W-1:0]    code_o,
    output logic [NCH-1:0]                forced_o
);

    strobe_t strb;
    logic    wen, upd_en, clr_en;
    logic [NCH-1:0][CODE_W-1:0] stg_nxt, stg_q, dac_nxt, dac_q;

    always_comb begin
        strb   = '{cs_n: cs_n, wr_n: wr_n, upd_n: upd_n, clr_n: clr_n};
        wen    = write_open(strb);
        upd_en = update_open(strb);
        clr_en = clear_active(strb);
    end

    dacif_stage_rank #(.NCH(NCH), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_stage (
        .clk(clk), .rst(rst), .wen(wen), .sel(sel), .din(din),
        .stg_nxt(stg_nxt), .stg_q(stg_q)
    );

    dacif_out_rank #(.NCH(NCH), .CODE_W(CODE_W)) u_out (
        .clk(clk), .rst(rst), .upd_en(upd_en),
        .stg_nxt(stg_nxt), .stg_q(stg_q),
        .dac_nxt(dac_nxt), .dac_q(dac_q)
    );

    dacif_out_stage #(.NCH(NCH), .CODE_W(CODE_W)) u_drv (
        .clk(clk), .rst(rst), .clr_en(clr_en),
        .dac_nxt(dac_nxt), .dac_q(dac_q),
        .code_o(code_o), .forced_o(forced_o)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (code_o == '0) && (forced_o == '0));

    assert_pass_through_R6: assert property (@(posedge clk) disable iff (rst)
        (wen && upd_en && !clr_en) |=> code_o[$past(sel)] == $past(din));

endmodule

// File: tb/sim_dacif_octal.sv
module sim_dacif_octal;

    localparam int NCH = 8;
    localparam int CW  = 13;

    logic clk = 0;
    logic rst = 1;
    logic cs_n = 1, wr_n = 1, upd_n = 1, clr_n = 1;
    logic [2:0] sel = '0;
    logic [CW-1:0] din = '0;
    logic [NCH-1:0][CW-1:0] code_o;
    logic [NCH-1:0] forced_o;

    int checks = 0;
    int errors = 0;

    logic [CW-1:0] m_stg [NCH];
    logic [CW-1:0] m_dac [NCH];
    logic          m_clr;

    always #4 clk = ~clk;

    dacif_octal u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n),
        .clr_n(clr_n), .sel(sel), .din(din), .code_o(code_o), .forced_o(forced_o)
    );

    function automatic logic [CW-1:0] exp_code(int ch);
        return m_clr ? '0 : m_dac[ch];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_stg[i] = '0;
            m_dac[i] = '0;
        end
        m_clr = 0;
    endtask

    task automatic model_edge();
        if (!cs_n && !wr_n) m_stg[sel] = din;
        if (!upd_n) for (int i = 0; i < NCH; i++) m_dac[i] = m_stg[i];
        m_clr = !clr_n;
    endtask

    task automatic step(input logic c, input logic w, input logic u,
                        input logic k, input logic [2:0] s, input logic [CW-1:0] d);
        cs_n = c; wr_n = w; upd_n = u; clr_n = k; sel = s; din = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic bad;
        bad = 0;
        checks++;
        for (int i = 0; i < NCH; i++) begin
            if (code_o[i] !== exp_code(i)) begin
                $display("FAIL %s ch%0d code actual=%0d expected=%0d", tag, i, code_o[i], exp_code(i));
                bad = 1;
            end
            if (forced_o[i] !== m_clr) begin
                $display("FAIL %s ch%0d flag actual=%0b expected=%0b", tag, i, forced_o[i], m_clr);
                bad = 1;
            end
        end
        if (bad) errors++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5420));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R1 reset state");

        // R2: write each channel, keep update closed, then one update
        for (int ch = 0; ch < NCH; ch++) begin
            step(0, 0, 1, 1, 3'(ch), CW'(ch * 1000 + 7));
            step(1, 1, 1, 1, 3'(ch), 13'h1FFF);
        end
        check_all("R5 hold while update closed");
        step(1, 1, 0, 1, 0, 0);
        step(1, 1, 1, 1, 0, 0);
        check_all("R2 binary channel decode");

        // R3: window follows bus, close by write strobe, then by chip select
        step(0, 0, 1, 1, 3, 100);
        step(0, 0, 1, 1, 3, 200);
        step(0, 0, 1, 1, 3, 8191);
        step(0, 1, 1, 1, 3, 555);
        step(1, 0, 1, 1, 3, 666);
        step(1, 1, 0, 1, 0, 0);
        step(1, 1, 1, 1, 0, 0);
        check_all("R3 capture on write close");
        step(0, 0, 1, 1, 4, 1234);
        step(1, 0, 1, 1, 4, 4321);
        step(1, 1, 0, 1, 4, 999);
        step(1, 1, 1, 1, 4, 999);
        check_all("R3 capture on select close");

        // R4: channel select moves inside open window
        step(0, 0, 1, 1, 1, 11);
        step(0, 0, 1, 1, 2, 22);
        step(0, 0, 1, 1, 2, 33);
        step(1, 1, 1, 1, 1, 44);
        step(1, 1, 0, 1, 0, 0);
        step(1, 1, 1, 1, 0, 0);
        check_all("R4 select change in window");

        // R6: pass-through with both ranks open
        step(0, 0, 0, 1, 5, 4000);
        check_all("R6 pass-through first");
        step(0, 0, 0, 1, 5, 17);
        check_all("R6 pass-through change");
        step(0, 0, 0, 1, 7, 8191);
        check_all("R6 pass-through max code");
        // R5: update closes while writing continues
        step(0, 0, 1, 1, 6, 77);
        step(0, 0, 1, 1, 6, 78);
        check_all("R5 update closed during write");
        step(1, 1, 0, 1, 0, 0);
        step(1, 1, 1, 1, 0, 0);
        check_all("R5 update after overlap");

        // R7 / R8: clear with update during clear
        step(1, 1, 1, 0, 0, 0);
        check_all("R7 clear forces zero");
        step(0, 0, 1, 0, 0, 3210);
        step(1, 1, 0, 0, 0, 0);
        step(1, 1, 1, 0, 0, 0);
        check_all("R8 clear during update");
        step(1, 1, 1, 1, 0, 0);
        check_all("R8 release shows new code");
        check_all("R7 release restores stored codes");

        // Random mixed strobes
        for (int n = 0; n < 600; n++) begin
            step(($urandom % 4) == 0 ? 1'b1 : 1'b0,
                 ($urandom % 3) == 0 ? 1'b1 : 1'b0,
                 ($urandom % 2) == 0 ? 1'b1 : 1'b0,
                 ($urandom % 6) == 0 ? 1'b0 : 1'b1,
                 3'($urandom), CW'($urandom));
            check_all("R5 R6 R7 random");
        end

        // R1 again: reset mid-run
        rst = 1;
        step(1, 1, 1, 1, 0, 0);
        model_reset();
        rst = 0;
        check_all("R1 reset after traffic");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule